// File: doc/BRIEF.md
# Low-Frequency Modulation Stepper for an FM Voice

This block steps a slow oscillator once per audio sample and turns its position into two modulation values for a four-operator FM voice. A wide phase accumulator, holding a 7-bit integer part above 25 fraction bits, gains a programmed increment on every sample strobe while the oscillator is enabled. The integer part, called the step, drives a triangle-shaped amplitude-modulation value and a coarser phase-modulation value. Both are recomputed only when the step moves.

On the same strobe the block forms each operator's attenuation level. It halves the sum of the operator's envelope attenuation and total level. Operators selected by a mask then get the amplitude-modulation value added, scaled down by a 2-bit sensitivity shift. Any operator whose level reaches the quiet threshold is flagged, so that the downstream operator can force its sample to zero. Larger levels mean more attenuation.

Top module: `lfo_mod_stepper`

## Requirements
- R1: While reset is high, and after it until the first sample strobe, all outputs are zero, including the accumulator state that they reflect.
- R2: On each strobe with the oscillator enabled, the accumulator adds `inc_i` modulo 2^32. The step is accumulator bits [31:25]. An increment that does not carry into bit 25 leaves `am_o` and `pm_o` unchanged.
- R3: `am_o` is twice the folded step. For a step below 64 this is 2*(step mod 64), and for a step of 64 or more it is 2*(63 - (step mod 64)). `am_o` therefore always lies in 0..126 and is even.
- R4: `pm_o` equals step >> 2 and changes only on a sample strobe.
- R5: Without a sample strobe every output holds its value, whatever the other inputs do.
- R6: With `lfo_en_i` low, a strobe leaves the accumulator frozen, so `am_o` and `pm_o` keep their values, and no modulation offset is added to any operator.
- R7: For operator k, whose fields are `att_i[10k+9:10k]` and `tl_i[10k+9:10k]`, the base level is (att + tl) >> 1. It appears on `eg_o[11k+10:11k]` after a strobe.
- R8: When `lfo_en_i` is high and `am_mask_i[k]` is set, operator k's level is the base level plus (`am_o` value of this strobe >> `ams_i`). When the mask bit is clear, the base level alone is used.
- R9: `silent_o[k]` is 1 exactly when operator k's level is 832 or more. A level of 831 is not silent.
- R10: The accumulator wraps from step 127 to step 0 without disturbing the fold, so step 0 after the wrap gives `am_o` = 0 and `pm_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| smp_i | input | 1 | One-cycle sample strobe |
| lfo_en_i | input | 1 | Oscillator enable |
| inc_i | input | 32 | Accumulator increment per sample |
| am_mask_i | input | 4 | Per-operator amplitude-modulation enable |
| ams_i | input | 2 | Amplitude-modulation sensitivity shift (0..3) |
| att_i | input | 40 | Packed per-operator envelope attenuation, 10 bits each |
| tl_i | input | 40 | Packed per-operator total level, 10 bits each |
| eg_o | output | 44 | Packed per-operator output level, 11 bits each |
| silent_o | output | 4 | Per-operator quiet flag |
| am_o | output | 7 | Amplitude-modulation value |
| pm_o | output | 5 | Phase-modulation value |

## Verification
The bench sweeps the step one unit per sample across the fold at 64 and the wrap at 128. A design that folded one step late or early, or that lost the doubling, shows a wrong `am_o` at exactly those samples. Levels are placed at 831 and 832, and the amplitude offset is also used to push a level across the threshold, which exposes an off-by-one comparison or a threshold applied before the offset is added. Strobes with the oscillator disabled and idle cycles with changed inputs catch an accumulator that keeps running or an offset that is not gated. Rotating the sensitivity shift and the mask catches a shift or an operator index that is swapped.

// File: rtl/lfo_stepper_pkg.sv
package lfo_stepper_pkg;
   localparam int LFO_AMS_W    = 2;
   localparam int LFO_ACC_DEF  = 32;
   localparam int LFO_FRAC_DEF = 25;

   // Fold a step of step_w bits into a triangle of step_w-1 bits:
   // the upper half of the range counts back down.
   function automatic logic [31:0] tri_fold(input logic [31:0] step, input int step_w);
      logic [31:0] low_mask;
      logic [31:0] low;
      low_mask = (32'd1 << (step_w - 1)) - 32'd1;
      low      = step & low_mask;
      if (((step >> (step_w - 1)) & 32'd1) != 32'd0)
         return low_mask - low;
      return low;
   endfunction
endpackage

// File: rtl/lfo_phase_acc.sv
module lfo_phase_acc
   import lfo_stepper_pkg::*;
#(
   parameter int ACC_W  = LFO_ACC_DEF,
   parameter int FRAC_W = LFO_FRAC_DEF,
   localparam int STEP_W = ACC_W - FRAC_W,
   localparam int AM_W   = STEP_W,
   localparam int PM_W   = STEP_W - 2
)(
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic            smp_i,
   input  logic            en_i,
   input  logic [ACC_W-1:0] inc_i,
   output logic [AM_W-1:0] am_live_o,
   output logic [AM_W-1:0] am_q_o,
   output logic [PM_W-1:0] pm_q_o
);
   logic [ACC_W-1:0]  acc_q;
   logic [ACC_W-1:0]  acc_sum;
   logic [STEP_W-1:0] prev_q;
   logic [STEP_W-1:0] step_n;
   logic              step_moved;
   logic              coarse_moved;
   logic [AM_W-1:0]   am_fold;
   logic [AM_W-1:0]   am_next;
   logic [PM_W-1:0]   pm_next;
   logic [31:0]       fold_w;

   always_comb begin
      acc_sum      = acc_q + inc_i;
      step_n       = acc_sum[ACC_W-1:FRAC_W];
      step_moved   = en_i && (step_n != prev_q);
      coarse_moved = step_moved && (step_n[STEP_W-1:2] != prev_q[STEP_W-1:2]);
      fold_w       = tri_fold(32'(step_n), STEP_W);
      am_fold      = {fold_w[STEP_W-2:0], 1'b0};
      am_next      = step_moved   ? am_fold : am_q_o;
      pm_next      = coarse_moved ? step_n[STEP_W-1:2] : pm_q_o;
   end

   assign am_live_o = am_next;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         acc_q  <= '0;
         prev_q <= '0;
         am_q_o <= '0;
         pm_q_o <= '0;
      end else if (smp_i && en_i) begin
         acc_q  <= acc_sum;
         prev_q <= step_n;
         am_q_o <= am_next;
         pm_q_o <= pm_next;
      end
   end
endmodule

// File: rtl/lfo_op_level.sv
module lfo_op_level
   import lfo_stepper_pkg::*;
#(
   parameter int ENV_W     = 10,
   parameter int AM_W      = 7,
   parameter int QUIET_LVL = 832,
   localparam int OUT_W    = ENV_W + 1
)(
   input  logic                 clk_i,
   input  logic                 rst_i,
   input  logic                 smp_i,
   input  logic [ENV_W-1:0]     att_i,
   input  logic [ENV_W-1:0]     tl_i,
   input  logic [AM_W-1:0]      am_i,
   input  logic                 am_on_i,
   input  logic [LFO_AMS_W-1:0] ams_i,
   output logic [OUT_W-1:0]     lvl_o,
   output logic                 silent_o
);
   logic [OUT_W-1:0] sum;
   logic [OUT_W-1:0] half;
   logic [OUT_W-1:0] offset;
   logic [OUT_W-1:0] lvl_n;

   always_comb begin
      sum    = {1'b0, att_i} + {1'b0, tl_i};
      half   = sum >> 1;
      offset = am_on_i ? OUT_W'(am_i >> ams_i) : '0;
      lvl_n  = half + offset;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         lvl_o    <= '0;
         silent_o <= 1'b0;
      end else if (smp_i) begin
         lvl_o    <= lvl_n;
         silent_o <= (lvl_n >= OUT_W'(QUIET_LVL));
      end
   end
endmodule

// File: rtl/lfo_mod_stepper.sv
module lfo_mod_stepper
   import lfo_stepper_pkg::*;
#(
   parameter int ACC_W     = LFO_ACC_DEF,
   parameter int FRAC_W    = LFO_FRAC_DEF,
   parameter int NUM_OPS   = 4,
   parameter int ENV_W     = 10,
   parameter int QUIET_LVL = 832,
   localparam int STEP_W   = ACC_W - FRAC_W,
   localparam int AM_W     = STEP_W,
   localparam int PM_W     = STEP_W - 2,
   localparam int OUT_W    = ENV_W + 1
)(
   input  logic                     clk_i,
   input  logic                     rst_i,
   input  logic                     smp_i,
   input  logic                     lfo_en_i,
   input  logic [ACC_W-1:0]         inc_i,
   input  logic [NUM_OPS-1:0]       am_mask_i,
   input  logic [LFO_AMS_W-1:0]     ams_i,
   input  logic [NUM_OPS*ENV_W-1:0] att_i,
   input  logic [NUM_OPS*ENV_W-1:0] tl_i,
   output logic [NUM_OPS*OUT_W-1:0] eg_o,
   output logic [NUM_OPS-1:0]       silent_o,
   output logic [AM_W-1:0]          am_o,
   output logic [PM_W-1:0]          pm_o
);
   if (STEP_W < 3) begin : g_bad_step
      $error("lfo_mod_stepper: ACC_W - FRAC_W must be at least 3");
   end
   if (QUIET_LVL >= (1 << OUT_W)) begin : g_bad_quiet
      $error("lfo_mod_stepper: QUIET_LVL does not fit the output level width");
   end
   if (NUM_OPS < 1) begin : g_bad_ops
      $error("lfo_mod_stepper: NUM_OPS must be positive");
   end

   logic [AM_W-1:0] am_live;
   logic [AM_W-1:0] am_gated;

   lfo_phase_acc #(
      .ACC_W (ACC_W),
      .FRAC_W(FRAC_W)
   ) u_acc (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .smp_i    (smp_i),
      .en_i     (lfo_en_i),
      .inc_i    (inc_i),
      .am_live_o(am_live),
      .am_q_o   (am_o),
      .pm_q_o   (pm_o)
   );

   assign am_gated = lfo_en_i ? am_live : '0;

   for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
      lfo_op_level #(
         .ENV_W    (ENV_W),
         .AM_W     (AM_W),
         .QUIET_LVL(QUIET_LVL)
      ) u_lvl (
         .clk_i   (clk_i),
         .rst_i   (rst_i),
         .smp_i   (smp_i),
         .att_i   (att_i[k*ENV_W +: ENV_W]),
         .tl_i    (tl_i[k*ENV_W +: ENV_W]),
         .am_i    (am_gated),
         .am_on_i (am_mask_i[k]),
         .ams_i   (ams_i),
         .lvl_o   (eg_o[k*OUT_W +: OUT_W]),
         .silent_o(silent_o[k])
      );
   end
endmodule

// File: rtl/lfo_stepper_chk.sv
module lfo_stepper_chk #(
   parameter int NUM_OPS   = 4,
   parameter int ENV_W     = 10,
   parameter int QUIET_LVL = 832,
   parameter int AM_W      = 7,
   parameter int PM_W      = 5,
   localparam int OUT_W    = ENV_W + 1
)(
   input logic                     clk_i,
   input logic                     rst_i,
   input logic                     smp_i,
   input logic                     lfo_en_i,
   input logic [NUM_OPS*OUT_W-1:0] eg_o,
   input logic [NUM_OPS-1:0]       silent_o,
   input logic [AM_W-1:0]          am_o,
   input logic [PM_W-1:0]          pm_o
);
   // R3: the triangle is doubled, so the value is always even
   assert_am_even_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      am_o[0] == 1'b0);

   // R4: the phase value moves only on a strobe
   assert_pm_on_strobe_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      !$stable(pm_o) |-> ($past(smp_i) || $past(rst_i)));

   // R5: no strobe, no change
   assert_hold_idle_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      !smp_i |=> ($stable(am_o) && $stable(pm_o) && $stable(eg_o) && $stable(silent_o)));

   // R6: a disabled oscillator stays frozen
   assert_frozen_off_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (smp_i && !lfo_en_i) |=> ($stable(am_o) && $stable(pm_o)));

   for (genvar k = 0; k < NUM_OPS; k++) begin : g_chk
      // R6: without modulation a level never exceeds the halved base range
      assert_no_offset_R6: assert property (@(posedge clk_i) disable iff (rst_i)
         (smp_i && !lfo_en_i) |=> (eg_o[k*OUT_W +: OUT_W] < OUT_W'(1 << ENV_W)));

      // R9: quiet flag agrees with the level
      assert_quiet_flag_R9: assert property (@(posedge clk_i) disable iff (rst_i)
         silent_o[k] == (eg_o[k*OUT_W +: OUT_W] >= OUT_W'(QUIET_LVL)));
   end
endmodule

bind lfo_mod_stepper lfo_stepper_chk #(
   .NUM_OPS  (NUM_OPS),
   .ENV_W    (ENV_W),
   .QUIET_LVL(QUIET_LVL),
   .AM_W     (AM_W),
   .PM_W     (PM_W)
) u_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .smp_i   (smp_i),
   .lfo_en_i(lfo_en_i),
   .eg_o    (eg_o),
   .silent_o(silent_o),
   .am_o    (am_o),
   .pm_o    (pm_o)
);

// File: tb/lfo_mod_stepper_test.sv
module lfo_mod_stepper_test;
   localparam int N  = 4;
   localparam int EW = 10;
   localparam int OW = 11;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          smp = 1'b0;
   logic          en  = 1'b0;
   logic [31:0]   inc = '0;
   logic [N-1:0]  mask = '0;
   logic [1:0]    ams = '0;
   logic [N*EW-1:0] att_bus;
   logic [N*EW-1:0] tl_bus;
   logic [N*OW-1:0] eg;
   logic [N-1:0]  sil;
   logic [6:0]    am;
   logic [4:0]    pm;

   int att_v[N];
   int tl_v[N];
   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] m_acc = '0;

   always #10 clk = ~clk;

   always_comb begin
      for (int k = 0; k < N; k++) begin
         att_bus[k*EW +: EW] = att_v[k][EW-1:0];
         tl_bus[k*EW +: EW]  = tl_v[k][EW-1:0];
      end
   end

   lfo_mod_stepper uut (
      .clk_i(clk), .rst_i(rst), .smp_i(smp), .lfo_en_i(en), .inc_i(inc),
      .am_mask_i(mask), .ams_i(ams), .att_i(att_bus), .tl_i(tl_bus),
      .eg_o(eg), .silent_o(sil), .am_o(am), .pm_o(pm)
   );

   task automatic chk(string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic set_all(int a, int t);
      for (int k = 0; k < N; k++) begin
         att_v[k] = a;
         tl_v[k]  = t;
      end
   endtask

   task automatic pulse();
      @(negedge clk) smp = 1'b1;
      @(negedge clk) smp = 1'b0;
      if (en) m_acc = m_acc + inc;
   endtask

   task automatic expect_all(string tag);
      int step, t, am_e, e;
      step = int'(m_acc[31:25]);
      t = step & 63;
      if (step >= 64) t = 63 - t;
      am_e = 2 * t;
      chk($sformatf("R3 %s am step %0d", tag, step), int'(am), am_e);
      chk($sformatf("R4 %s pm step %0d", tag, step), int'(pm), step >> 2);
      for (int k = 0; k < N; k++) begin
         e = (att_v[k] + tl_v[k]) / 2 + ((en && mask[k]) ? (am_e >> ams) : 0);
         chk($sformatf("R7/R8 %s op%0d level", tag, k), int'(eg[k*OW +: OW]), e);
         chk($sformatf("R9 %s op%0d quiet", tag, k), int'(sil[k]), (e >= 832) ? 1 : 0);
      end
   endtask

   task automatic t_reset();
      set_all(300, 300);
      mask = '1;
      repeat (3) @(negedge clk);
      chk("R1 am in reset", int'(am), 0);
      chk("R1 pm in reset", int'(pm), 0);
      chk("R1 levels in reset", int'(eg), 0);
      chk("R1 quiet in reset", int'(sil), 0);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 levels before first strobe", int'(eg), 0);
      chk("R1 am before first strobe", int'(am), 0);
      en = 1'b1;
      inc = 32'd5;
      pulse();
      expect_all("R2 small increment");
   endtask

   task automatic t_plain();
      en = 1'b0;
      mask = 4'hF;
      att_v[0] = 100;  tl_v[0] = 300;
      att_v[1] = 0;    tl_v[1] = 0;
      att_v[2] = 1023; tl_v[2] = 1023;
      att_v[3] = 512;  tl_v[3] = 1;
      pulse();
      expect_all("R7 base");
   endtask

   task automatic t_quiet();
      en = 1'b0;
      att_v[0] = 831; tl_v[0] = 831;
      att_v[1] = 832; tl_v[1] = 831;
      att_v[2] = 832; tl_v[2] = 832;
      att_v[3] = 833; tl_v[3] = 832;
      pulse();
      expect_all("R9 threshold");
   endtask

   task automatic t_sweep();
      en = 1'b1;
      inc = 32'h0200_0000;
      mask = 4'b0101;
      set_all(400, 400);
      for (int i = 0; i < 132; i++) begin
         ams = 2'(i % 4);
         pulse();
         expect_all("R2/R10 sweep");
      end
   endtask

   task automatic t_push();
      en = 1'b1;
      inc = 32'h0300_0000;
      mask = 4'b1011;
      set_all(750, 750);
      att_v[2] = 700;
      for (int i = 0; i < 100; i++) begin
         ams = 2'((i / 3) % 4);
         pulse();
         expect_all("R8/R9 push");
      end
   endtask

   task automatic t_disable();
      logic [6:0] am0;
      logic [4:0] pm0;
      am0 = am;
      pm0 = pm;
      en = 1'b0;
      inc = 32'h1234_5678;
      mask = 4'hF;
      ams = 2'd0;
      set_all(780, 790);
      for (int i = 0; i < 5; i++) begin
         pulse();
         chk("R6 am frozen", int'(am), int'(am0));
         chk("R6 pm frozen", int'(pm), int'(pm0));
         expect_all("R6 off");
      end
   endtask

   task automatic t_hold();
      logic [N*OW-1:0] eg0;
      logic [N-1:0]    sil0;
      logic [6:0]      am0;
      logic [4:0]      pm0;
      eg0 = eg; sil0 = sil; am0 = am; pm0 = pm;
      en = 1'b1;
      inc = 32'hFFFF_FFFF;
      mask = 4'hF;
      set_all(1023, 1023);
      repeat (4) @(negedge clk);
      chk("R5 levels held", int'(eg), int'(eg0));
      chk("R5 quiet held", int'(sil), int'(sil0));
      chk("R5 am held", int'(am), int'(am0));
      chk("R5 pm held", int'(pm), int'(pm0));
   endtask

   initial begin
      set_all(0, 0);
      t_reset();
      t_plain();
      t_quiet();
      t_sweep();
      t_push();
      t_disable();
      t_hold();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(20 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule